// File: doc/BRIEF.md
# Triple-Sample Operating Point Tuner

This controller searches for the edge of safe operation of one monitored timing path. Three latches strobe the path output at slightly staggered moments; the latest strobe is taken as the settled value. Comparing the early strobe with the middle one, and the middle one with the late one, tells the controller whether the path is failing, sitting right at its limit, or still has slack. The controller then moves a 6-bit operating-point code one step at a time. Higher codes are more aggressive, for example a faster clock divider setting or a lower supply index.

A start pulse puts the code at its most conservative value and begins a run. Every `EVAL_GAP` cycles the controller reads the three strobes and judges them once. Between judgements the path is given time to settle at the new setting. The run ends with the tuned flag high once the limit condition has been seen on `CONFIRM` judgements in a row. The code is then frozen until the next start. Generating the clock or voltage itself is left to the surrounding logic.

Top module: `tst_tuner`

## Requirements
- R1: While `rst` is high at a rising edge, the next cycle shows `op_code` = 0, `tuned` = 0 and `busy` = 0.
- R2: A cycle with `start` high sets `op_code` to 0, clears `tuned` and raises `busy` on the following cycle. This holds whatever the samples are.
- R3: After a start, judgements happen at the rising edges that come `EVAL_GAP`, 2·`EVAL_GAP`, … cycles after the start edge. `op_code` changes at no other edge.
- R4: At a judgement where `samp_early` = `samp_mid` = `samp_late`, `op_code` rises by 1. It saturates at 63.
- R5: At a judgement where `samp_mid` ≠ `samp_late`, `op_code` falls by 1. It saturates at 0.
- R6: At a judgement where `samp_early` ≠ `samp_mid` and `samp_mid` = `samp_late`, `op_code` is left unchanged.
- R7: `tuned` rises, and `busy` falls, at the judgement that completes `CONFIRM` consecutive R6 outcomes. Any R4 or R5 outcome restarts that streak from zero.
- R8: While `busy` is low and `start` is low, the samples have no effect: `op_code`, `tuned` and `busy` hold.
- R9: A start while a run is busy restarts the run: the code goes back to 0, the streak is cleared and the judgement spacing is counted from the new start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins or restarts a tuning run |
| samp_early | input | 1 | Path output strobed first |
| samp_mid | input | 1 | Path output strobed second |
| samp_late | input | 1 | Path output strobed last (settled value) |
| op_code | output | 6 | Operating-point code, 0 is most conservative |
| tuned | output | 1 | Limit condition confirmed, code frozen |
| busy | output | 1 | Run in progress |

## Verification
The bench builds the tuner with `EVAL_GAP` = 4 and `CONFIRM` = 2. With a gap this short, a full climb from 0 to the saturation ceiling of 63 takes a few hundred cycles, and so does the matching descent back to 0. Both saturation ends therefore fall inside one run. A confirm depth of two makes it possible to interrupt a streak after a single limit judgement and then complete one, and a restart can land at any phase of the judgement spacing.

// File: rtl/tst_pkg.sv
package tst_pkg;
  typedef enum logic [1:0] {
    VERD_RAISE = 2'd0,
    VERD_LOWER = 2'd1,
    VERD_HOLD  = 2'd2
  } verdict_t;
endpackage

// File: rtl/tst_classifier.sv
module tst_classifier
  import tst_pkg::*;
(
  input  logic     s_a,
  input  logic     s_b,
  input  logic     s_c,
  output verdict_t verdict
);
  logic a_vs_b;
  logic b_vs_c;

  always_comb begin
    a_vs_b = s_a ^ s_b;
    b_vs_c = s_b ^ s_c;
    if (b_vs_c)
      verdict = VERD_LOWER;
    else if (a_vs_b)
      verdict = VERD_HOLD;
    else
      verdict = VERD_RAISE;
  end
endmodule

// File: rtl/tst_pacer.sv
module tst_pacer #(
  parameter int GAP = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic tick
);
  localparam int CW = (GAP > 2) ? $clog2(GAP) : 1;
  localparam logic [CW-1:0] LAST = CW'(GAP - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)
      cnt <= '0;
    else if (run)
      cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tick = run && (cnt == LAST);
endmodule

// File: rtl/tst_stepper.sv
module tst_stepper #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         up,
  input  logic         down,
  output logic [W-1:0] code
);
  localparam logic [W-1:0] TOP = {W{1'b1}};

  always_ff @(posedge clk) begin
    if (rst || clear)
      code <= '0;
    else if (up && code != TOP)
      code <= code + 1'b1;
    else if (down && code != '0)
      code <= code - 1'b1;
  end
endmodule

// File: rtl/tst_tuner.sv
module tst_tuner
  import tst_pkg::*;
#(
  parameter int CODE_W   = 6,
  parameter int EVAL_GAP = 16,
  parameter int CONFIRM  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic              samp_early,
  input  logic              samp_mid,
  input  logic              samp_late,
  output logic [CODE_W-1:0] op_code,
  output logic              tuned,
  output logic              busy
);
  localparam int SW = (CONFIRM > 1) ? $clog2(CONFIRM) : 1;
  localparam logic [SW-1:0] STREAK_LAST = SW'(CONFIRM - 1);

  verdict_t      verdict;
  logic          tick;
  logic          judge;
  logic [SW-1:0] streak;

  tst_classifier u_cls (
    .s_a    (samp_early),
    .s_b    (samp_mid),
    .s_c    (samp_late),
    .verdict(verdict)
  );

  tst_pacer #(.GAP(EVAL_GAP)) u_pace (
    .clk  (clk),
    .rst  (rst),
    .clear(start),
    .run  (busy),
    .tick (tick)
  );

  assign judge = tick && !start;

  tst_stepper #(.W(CODE_W)) u_step (
    .clk  (clk),
    .rst  (rst),
    .clear(start),
    .up   (judge && verdict == VERD_RAISE),
    .down (judge && verdict == VERD_LOWER),
    .code (op_code)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tuned  <= 1'b0;
      busy   <= 1'b0;
      streak <= '0;
    end else if (start) begin
      tuned  <= 1'b0;
      busy   <= 1'b1;
      streak <= '0;
    end else if (judge) begin
      if (verdict == VERD_HOLD) begin
        if (streak == STREAK_LAST) begin
          tuned  <= 1'b1;
          busy   <= 1'b0;
          streak <= '0;
        end else begin
          streak <= streak + 1'b1;
        end
      end else begin
        streak <= '0;
      end
    end
  end
endmodule

// File: rtl/tst_tuner_checker.sv
module tst_tuner_checker #(
  parameter int CODE_W   = 6,
  parameter int EVAL_GAP = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [CODE_W-1:0] op_code,
  input logic              tuned,
  input logic              busy
);
  localparam int CW = (EVAL_GAP > 2) ? $clog2(EVAL_GAP) : 1;

  logic [CW-1:0] phase;
  always_ff @(posedge clk) begin
    if (rst || start)
      phase <= '0;
    else if (busy)
      phase <= (phase == CW'(EVAL_GAP - 1)) ? '0 : phase + 1'b1;
  end

  logic [CODE_W:0] wide_code;
  assign wide_code = {1'b0, op_code};

  a_r1_reset_state: assert property (@(posedge clk)
    rst |=> (op_code == '0 && !tuned && !busy));

  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (op_code == '0 && !tuned && busy));

  a_r3_off_phase_stable: assert property (@(posedge clk) disable iff (rst)
    (busy && !start && phase != CW'(EVAL_GAP - 1)) |=> $stable(op_code));

  a_r4_r5_single_step: assert property (@(posedge clk) disable iff (rst)
    !start |=> (wide_code == {1'b0, $past(op_code)}
             || wide_code == {1'b0, $past(op_code)} + 1'b1
             || wide_code + 1'b1 == {1'b0, $past(op_code)}));

  a_r7_tuned_idle: assert property (@(posedge clk) disable iff (rst)
    tuned |-> !busy);

  a_r8_idle_frozen: assert property (@(posedge clk) disable iff (rst)
    (!busy && !start) |=> ($stable(op_code) && $stable(tuned) && !busy));
endmodule

bind tst_tuner tst_tuner_checker #(
  .CODE_W  (CODE_W),
  .EVAL_GAP(EVAL_GAP)
) u_tst_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .op_code(op_code),
  .tuned  (tuned),
  .busy   (busy)
);

// File: tb/tst_tuner_bench.sv
module tst_tuner_bench;
  localparam int CW  = 6;
  localparam int GAP = 4;
  localparam int CNF = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start = 1'b0;
  logic se = 1'b0, sm = 1'b0, sl = 1'b0;
  logic [CW-1:0] op_code;
  logic tuned, busy;

  always #10 clk = ~clk;

  tst_tuner #(.CODE_W(CW), .EVAL_GAP(GAP), .CONFIRM(CNF)) u_tst_tuner (
    .clk(clk), .rst(rst), .start(start),
    .samp_early(se), .samp_mid(sm), .samp_late(sl),
    .op_code(op_code), .tuned(tuned), .busy(busy)
  );

  int total = 0;
  int bad = 0;
  int cycles = 0;
  string tag = "R1";
  bit done = 1'b0;

  int m_code = 0;
  bit m_tuned = 1'b0;
  bit m_busy = 1'b0;
  int m_cnt = 0;
  int m_streak = 0;

  // 0 raise, 1 lower, 2 hold
  function automatic int judge_of(bit e, bit m, bit l);
    if (m != l) return 1;
    if (e != m) return 2;
    return 0;
  endfunction

  task automatic model_step(bit r, bit s, bit e, bit m, bit l);
    int v;
    if (r) begin
      m_code = 0; m_tuned = 0; m_busy = 0; m_cnt = 0; m_streak = 0;
    end else if (s) begin
      m_code = 0; m_tuned = 0; m_busy = 1; m_cnt = 0; m_streak = 0;
    end else if (m_busy) begin
      if (m_cnt == GAP - 1) begin
        m_cnt = 0;
        v = judge_of(e, m, l);
        if (v == 0) begin
          if (m_code < 63) m_code++;
          m_streak = 0;
        end else if (v == 1) begin
          if (m_code > 0) m_code--;
          m_streak = 0;
        end else begin
          m_streak++;
          if (m_streak == CNF) begin
            m_tuned = 1; m_busy = 0; m_streak = 0;
          end
        end
      end else begin
        m_cnt++;
      end
    end
  endtask

  task automatic check_outputs();
    total++;
    if (op_code !== CW'(m_code)) begin
      bad++;
      $display("FAIL %s op_code actual=%0d expected=%0d", tag, op_code, m_code);
    end
    total++;
    if (tuned !== m_tuned) begin
      bad++;
      $display("FAIL %s tuned actual=%0b expected=%0b", tag, tuned, m_tuned);
    end
    total++;
    if (busy !== m_busy) begin
      bad++;
      $display("FAIL %s busy actual=%0b expected=%0b", tag, busy, m_busy);
    end
  endtask

  // one clock: drive at negedge, model consumes the same inputs at the posedge
  task automatic cyc(bit r, bit s, bit e, bit m, bit l);
    @(negedge clk);
    check_outputs();
    rst = r; start = s; se = e; sm = m; sl = l;
    model_step(r, s, e, m, l);
    cycles++;
  endtask

  task automatic run_pat(int n, bit e, bit m, bit l);
    for (int i = 0; i < n; i++) cyc(0, 0, e, m, l);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    int x;
    void'($urandom(32'd4242));
    // R1: reset state
    tag = "R1";
    cyc(1, 0, 0, 0, 0); cyc(1, 0, 1, 1, 1); cyc(0, 0, 1, 1, 1);
    // R8: idle before any start, samples ignored
    tag = "R8";
    for (int i = 0; i < 12; i++) cyc(0, 0, 1'($urandom), 1'($urandom), 1'($urandom));
    // R2 then R3 spacing with all-agree pattern
    tag = "R2"; cyc(0, 1, 0, 1, 1); cyc(0, 0, 1, 1, 1);
    tag = "R3"; run_pat(3 * GAP, 1, 1, 1);
    // R4: climb to saturation at 63
    tag = "R4"; run_pat(70 * GAP, 0, 0, 0);
    // R5: descend to saturation at 0
    tag = "R5"; run_pat(70 * GAP, 1, 1, 0);
    tag = "R5"; run_pat(2 * GAP, 0, 1, 0);
    // climb a little, then hold once and break the streak
    tag = "R4"; run_pat(5 * GAP, 1, 1, 1);
    tag = "R6"; run_pat(GAP, 1, 0, 0);
    tag = "R7"; run_pat(GAP, 0, 0, 0);
    tag = "R6"; run_pat(GAP, 0, 1, 1);
    tag = "R7"; run_pat(GAP, 1, 1, 0);
    tag = "R7"; run_pat(2 * GAP + 2, 1, 0, 0);
    // R8: tuned and idle, samples ignored
    tag = "R8";
    for (int i = 0; i < 40; i++) cyc(0, 0, 1'($urandom), 1'($urandom), 1'($urandom));
    // R9: restart mid-run at an odd phase
    tag = "R9";
    cyc(0, 1, 0, 0, 0);
    run_pat(5 * GAP + 1, 1, 1, 1);
    cyc(0, 1, 1, 1, 1);
    run_pat(3 * GAP + 3, 1, 1, 1);
    cyc(0, 0, 0, 1, 1);
    cyc(0, 1, 0, 1, 1);
    run_pat(2 * GAP, 0, 1, 1);
    // mixed random traffic
    tag = "R3";
    for (int i = 0; i < 4000; i++) begin
      x = $urandom_range(0, 9);
      if (x < 4) cyc(0, ($urandom_range(0, 150) == 0), 1, 1, 1);
      else if (x < 6) cyc(0, ($urandom_range(0, 150) == 0), 0, 1, 0);
      else cyc(0, ($urandom_range(0, 150) == 0), 1'($urandom), 1'($urandom), 1'($urandom));
    end
    cyc(0, 0, 0, 0, 0);
    finish_up();
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_up();
  end
endmodule